// File: doc/BRIEF.md
# Modulo Counter Compare Channel

A single 16-bit timer channel for use inside a larger timing subsystem. Its counter advances by one on each count strobe, upward or downward. The strobe comes from one of two sources: a free-running prescaler that divides the peripheral clock by a power of two, or rising edges on an external input after synchronization. The block compares the count against two compare registers. When the count reaches the terminal value for the current direction, the counter reinitializes. The reinitialization value is the load register, or in modulo mode a compare preload register.

A match drives an output flag according to a two-bit action code, which can hold, set, clear or toggle it. A match also latches a pending-event bit that can raise an interrupt. When preload is on, the match swaps in the matching compare register's preload value. A one-shot mode stops counting after the first terminal event. Software configures the channel through a small write/read register port, and a count-enable input gates all counting.

Top module: `mod_cmp_timer`

## Requirements
- R1: Each count strobe, taken while `cnt_en` is high and the channel is not stopped, changes COUNT (address 6) by +1 when CTRL bit 4 is 0 and by -1 when it is 1, wrapping in 16 bits.
- R2: The terminal value is CMP1 (address 2) when counting up and CMP2 (address 3) when counting down. A strobe taken at the terminal value reloads COUNT from LOAD (address 1).
- R3: With CTRL bit 6 set (modulo), the terminal reload value is PRE1 (address 4) when counting up and PRE2 (address 5) when counting down.
- R4: A strobe taken while COUNT equals CMP1 or CMP2 applies the action in CTRL[8:7] to `flag_out`: 00 holds, 01 sets, 10 clears, 11 toggles. The action is applied once even when both registers match.
- R5: With CTRL bit 9 set, a match on CMP1 copies PRE1 into CMP1, and a match on CMP2 copies PRE2 into CMP2.
- R6: A match sets STAT bit 0 (address 7), and writing 1 to that bit clears it. `irq` is STAT bit 0 ANDed with CTRL bit 10.
- R7: With CTRL bit 3 clear, the strobe comes from the prescaler, which divides the clock by 2^N, where N is CTRL[2:0]. 16 enabled cycles with N=2 give exactly 4 counts.
- R8: With CTRL bit 3 set, each rising edge of `ext_clk` gives one count after a two-flop synchronizer. A level held high gives a single count, and strobes are never closer than two cycles apart.
- R9: With CTRL bit 5 set (one-shot), the terminal reload stops the channel and sets STAT bit 1. Any CTRL write restarts the channel.
- R10: While `cnt_en` is low, COUNT does not change, except through register writes.
- R11: A write to COUNT or to a compare register in the same cycle as a reload or a preload takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cnt_en | input | 1 | Count enable |
| ext_clk | input | 1 | External count input (asynchronous) |
| flag_out | output | 1 | Compare-driven output flag |
| irq | output | 1 | Match interrupt |

## Verification
Counting is exercised in four ways: up and down runs that wrap at the terminal value, and modulo runs that reload from a preload register. Runs stop on either side of the terminal step, so an off-by-one reload or a swapped terminal register shows up as a wrong count. The flag is driven through every action code, and once with both compare registers equal, to tell a single applied action from a doubled one. Strobe sources are compared with a prescaler window count, external pulses and a held-high external level, which separates edge detection from level sensitivity.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int CW = 16;
  localparam int NW = 3;
  localparam int PSW = (1 << NW) - 1;
  localparam int CTRL_W = 11;

  localparam int B_EXT = 3;
  localparam int B_DOWN = 4;
  localparam int B_ONCE = 5;
  localparam int B_MOD = 6;
  localparam int B_ACT = 7;
  localparam int B_PRE = 9;
  localparam int B_IRQ = 10;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_LOAD = 3'd1;
  localparam logic [2:0] A_CMP1 = 3'd2;
  localparam logic [2:0] A_CMP2 = 3'd3;
  localparam logic [2:0] A_PRE1 = 3'd4;
  localparam logic [2:0] A_PRE2 = 3'd5;
  localparam logic [2:0] A_CNT = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;

  typedef enum logic [1:0] {ACT_HOLD = 2'b00, ACT_SET = 2'b01, ACT_CLR = 2'b10, ACT_TGL = 2'b11} act_e;

  function automatic logic [PSW-1:0] div_mask(input logic [NW-1:0] n);
    logic [PSW-1:0] m;
    for (int i = 0; i < PSW; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  function automatic logic psc_hit(input logic [PSW-1:0] psc, input logic [NW-1:0] n);
    return (psc & div_mask(n)) == div_mask(n);
  endfunction

  function automatic logic [CW-1:0] step_cnt(input logic [CW-1:0] c, input logic down);
    return down ? c - 1'b1 : c + 1'b1;
  endfunction

  function automatic logic apply_act(input logic f, input act_e a);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~f;
      default: return f;
    endcase
  endfunction
endpackage

// File: rtl/mct_tick_gen.sv
module mct_tick_gen
  import mct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_sel,
  input  logic [NW-1:0] div_n,
  input  logic          ext_clk,
  output logic          strobe
);
  logic [PSW-1:0] psc_q;
  logic [1:0]     sync_q;
  logic           prev_q;
  logic           ext_edge;
  logic           psc_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      psc_q  <= psc_q + 1'b1;
      sync_q <= {sync_q[0], ext_clk};
      prev_q <= sync_q[1];
    end
  end

  assign ext_edge   = sync_q[1] & ~prev_q;
  assign psc_strobe = psc_hit(psc_q, div_n);
  assign strobe     = ext_sel ? ext_edge : psc_strobe;

  assert_ext_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && ext_edge) |=> !ext_edge);
endmodule

// File: rtl/mct_counter.sv
module mct_counter
  import mct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          terminal,
  input  logic          down,
  input  logic          oneshot,
  input  logic [CW-1:0] reload_val,
  input  logic          cnt_wr,
  input  logic          ctrl_wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic          stopped
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      stopped <= 1'b0;
    end else begin
      if (cnt_wr) cnt <= wdata;
      else if (tick) cnt <= terminal ? reload_val : step_cnt(cnt, down);
      if (ctrl_wr) stopped <= 1'b0;
      else if (tick && terminal && oneshot) stopped <= 1'b1;
    end
  end

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && terminal && !cnt_wr) |=> cnt == $past(reload_val));
  assert_wr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata));
  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !cnt_wr && !ctrl_wr) |=> $stable(cnt));
endmodule

// File: rtl/mct_compare.sv
module mct_compare
  import mct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          pre_en,
  input  act_e          act,
  input  logic [CW-1:0] pre1,
  input  logic [CW-1:0] pre2,
  input  logic          wr_c1,
  input  logic          wr_c2,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cmp1,
  output logic [CW-1:0] cmp2,
  output logic          match1,
  output logic          match2,
  output logic          flag
);
  assign match1 = tick && (cnt == cmp1);
  assign match2 = tick && (cnt == cmp2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp1 <= '0;
      cmp2 <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_c1) cmp1 <= wdata;
      else if (match1 && pre_en) cmp1 <= pre1;
      if (wr_c2) cmp2 <= wdata;
      else if (match2 && pre_en) cmp2 <= pre2;
      if (match1 || match2) flag <= apply_act(flag, act);
    end
  end

  assert_preload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match1 && pre_en && !wr_c1) |=> cmp1 == $past(pre1));
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((match1 || match2) && act == ACT_SET) |=> flag);
  assert_flag_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(match1 || match2) |=> $stable(flag));
endmodule

// File: rtl/mod_cmp_timer.sv
module mod_cmp_timer
  import mct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          cnt_en,
  input  logic          ext_clk,
  output logic          flag_out,
  output logic          irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0]     load_q, pre1_q, pre2_q;
  logic [CW-1:0]     cnt, cmp1, cmp2, reload_val;
  logic              stat_q, stopped, strobe, tick, terminal, match1, match2;
  logic              down;

  wire wr_ctrl = wr_en && wr_addr == A_CTRL;
  wire wr_cnt  = wr_en && wr_addr == A_CNT;
  wire wr_c1   = wr_en && wr_addr == A_CMP1;
  wire wr_c2   = wr_en && wr_addr == A_CMP2;
  wire wr_stat = wr_en && wr_addr == A_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      pre1_q <= '0;
      pre2_q <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_en && wr_addr == A_LOAD) load_q <= wr_data;
      if (wr_en && wr_addr == A_PRE1) pre1_q <= wr_data;
      if (wr_en && wr_addr == A_PRE2) pre2_q <= wr_data;
      if (match1 || match2) stat_q <= 1'b1;
      else if (wr_stat && wr_data[0]) stat_q <= 1'b0;
    end
  end

  assign down       = ctrl_q[B_DOWN];
  assign tick       = strobe && cnt_en && !stopped;
  assign terminal   = down ? match2 : match1;
  assign reload_val = ctrl_q[B_MOD] ? (down ? pre2_q : pre1_q) : load_q;
  assign irq        = stat_q && ctrl_q[B_IRQ];

  mct_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .ext_sel(ctrl_q[B_EXT]), .div_n(ctrl_q[NW-1:0]),
    .ext_clk(ext_clk), .strobe(strobe)
  );

  mct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .terminal(terminal), .down(down),
    .oneshot(ctrl_q[B_ONCE]), .reload_val(reload_val), .cnt_wr(wr_cnt),
    .ctrl_wr(wr_ctrl), .wdata(wr_data), .cnt(cnt), .stopped(stopped)
  );

  mct_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .pre_en(ctrl_q[B_PRE]),
    .act(act_e'(ctrl_q[B_ACT+1:B_ACT])), .pre1(pre1_q), .pre2(pre2_q),
    .wr_c1(wr_c1), .wr_c2(wr_c2), .wdata(wr_data), .cmp1(cmp1), .cmp2(cmp2),
    .match1(match1), .match2(match2), .flag(flag_out)
  );

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = CW'(ctrl_q);
      A_LOAD:  rd_data = load_q;
      A_CMP1:  rd_data = cmp1;
      A_CMP2:  rd_data = cmp2;
      A_PRE1:  rd_data = pre1_q;
      A_PRE2:  rd_data = pre2_q;
      A_CNT:   rd_data = cnt;
      default: rd_data = {{(CW-2){1'b0}}, stopped, stat_q};
    endcase
  end

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_cnt) |=> $stable(cnt));
  assert_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match1 || match2) |=> stat_q);
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !terminal && !wr_cnt) |=> cnt == $past(down ? cnt - 16'd1 : cnt + 16'd1));
endmodule

// File: tb/tb_mod_cmp_timer.sv
module tb_mod_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cnt_en = 1'b0;
  logic        ext_clk = 1'b0;
  logic        flag_out, irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mod_cmp_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_en(cnt_en), .ext_clk(ext_clk),
    .flag_out(flag_out), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1 v = int'(rd_data);
  endtask

  task automatic cfg(input logic [15:0] c, input logic [15:0] ld, input logic [15:0] c1,
                     input logic [15:0] c2, input logic [15:0] p1, input logic [15:0] p2,
                     input logic [15:0] cv);
    wr(3'd0, c); wr(3'd1, ld); wr(3'd2, c1); wr(3'd3, c2);
    wr(3'd4, p1); wr(3'd5, p2); wr(3'd6, cv); wr(3'd7, 16'h0001);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  function automatic int wrap_up(input int lo, input int hi, input int start, input int n);
    int span = hi - lo + 1;
    return lo + ((start - lo + n) % span);
  endfunction

  task automatic t_reset();
    int v;
    rd(3'd6, v); check("R1 reset count", v, 0);
    check("R4 reset flag", flag_out, 0);
    check("R6 reset irq", irq, 0);
  endtask

  task automatic t_updown();
    int v;
    cfg(16'h0000, 5, 8, 16'hFFFF, 0, 0, 5);
    run(3); rd(3'd6, v); check("R1 up count", v, wrap_up(5, 8, 5, 3));
    run(1); rd(3'd6, v); check("R2 up reload from LOAD", v, 5);
    run(6); rd(3'd6, v); check("R2 up wrap", v, wrap_up(5, 8, 5, 10));
    cfg(16'h0010, 20, 16'hFFFF, 17, 0, 0, 20);
    run(2); rd(3'd6, v); check("R1 down count", v, 18);
    run(2); rd(3'd6, v); check("R2 down reload at CMP2", v, 20);
    cfg(16'h0010, 0, 16'h0005, 16'h0001, 0, 0, 0);
    run(1); rd(3'd6, v); check("R1 down 16-bit wrap", v, 16'hFFFF);
  endtask

  task automatic t_modulo();
    int v;
    cfg(16'h0040, 9, 4, 16'hFFFF, 2, 0, 0);
    run(5); rd(3'd6, v); check("R3 up modulo reload PRE1", v, 2);
    run(1); rd(3'd6, v); check("R3 up modulo continue", v, 3);
    cfg(16'h0050, 9, 16'hFFFF, 28, 0, 30, 29);
    run(2); rd(3'd6, v); check("R3 down modulo reload PRE2", v, 30);
  endtask

  task automatic t_flag();
    cfg(16'h0180, 0, 3, 16'hFFFF, 0, 0, 0);
    run(4); check("R4 toggle on", flag_out, 1);
    run(4); check("R4 toggle off", flag_out, 0);
    wr(3'd0, 16'h0080); run(4); check("R4 set", flag_out, 1);
    wr(3'd0, 16'h0100); run(4); check("R4 clear", flag_out, 0);
    wr(3'd0, 16'h0000); run(3); check("R4 hold before match", flag_out, 0);
    run(1); check("R4 hold at match", flag_out, 0);
    cfg(16'h0180, 0, 3, 3, 0, 0, 0);
    run(4); check("R4 dual match applies once", flag_out, 1);
    wr(3'd0, 16'h0100); run(4); check("R4 clear again", flag_out, 0);
  endtask

  task automatic t_preload();
    int v;
    cfg(16'h0200, 0, 3, 16'hFFFF, 6, 0, 0);
    run(4); rd(3'd2, v); check("R5 CMP1 takes PRE1", v, 6);
    rd(3'd6, v); check("R5 reload at old CMP1", v, 0);
    run(7); rd(3'd6, v); check("R5 new terminal used", v, 0);
    cfg(16'h0210, 8, 16'hFFFF, 8, 0, 5, 8);
    run(1); rd(3'd3, v); check("R5 CMP2 takes PRE2", v, 5);
    rd(3'd2, v); check("R5 CMP1 untouched", v, 16'hFFFF);
  endtask

  task automatic t_irq();
    int v;
    cfg(16'h0400, 0, 2, 16'hFFFF, 0, 0, 0);
    run(2); check("R6 no irq before match", irq, 0);
    run(1); check("R6 irq on match", irq, 1);
    wr(3'd7, 16'h0001); check("R6 irq cleared by W1C", irq, 0);
    rd(3'd7, v); check("R6 status cleared", v & 1, 0);
    cfg(16'h0000, 0, 2, 16'hFFFF, 0, 0, 0);
    run(3); rd(3'd7, v); check("R6 status set without enable", v & 1, 1);
    check("R6 irq masked", irq, 0);
  endtask

  task automatic t_prescale();
    int v;
    cfg(16'h0002, 0, 16'hFFFF, 16'hFFFF, 0, 0, 0);
    run(16); rd(3'd6, v); check("R7 divide by 4", v, 4);
    cfg(16'h0003, 0, 16'hFFFF, 16'hFFFF, 0, 0, 0);
    run(32); rd(3'd6, v); check("R7 divide by 8", v, 4);
  endtask

  task automatic t_ext();
    int v;
    cfg(16'h0008, 0, 16'hFFFF, 16'hFFFF, 0, 0, 0);
    @(negedge clk); cnt_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ext_clk = 1'b1; repeat (2) @(negedge clk);
      ext_clk = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(3'd6, v); check("R8 five edges", v, 5);
    ext_clk = 1'b1; repeat (20) @(negedge clk);
    rd(3'd6, v); check("R8 held level counts once", v, 6);
    ext_clk = 1'b0; repeat (4) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_idle();
    int v;
    cfg(16'h0000, 0, 16'hFFFF, 16'hFFFF, 0, 0, 42);
    repeat (10) @(negedge clk);
    rd(3'd6, v); check("R10 disabled holds", v, 42);
  endtask

  task automatic t_oneshot();
    int v;
    cfg(16'h0020, 0, 2, 16'hFFFF, 0, 0, 0);
    run(10); rd(3'd6, v); check("R9 stopped after terminal", v, 0);
    rd(3'd7, v); check("R9 stop status", (v >> 1) & 1, 1);
    wr(3'd0, 16'h0020); rd(3'd7, v); check("R9 ctrl write restarts", (v >> 1) & 1, 0);
    run(1); rd(3'd6, v); check("R9 counts after restart", v, 1);
  endtask

  task automatic t_override();
    int v;
    cfg(16'h0000, 0, 7, 16'hFFFF, 0, 0, 7);
    @(negedge clk);
    cnt_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd6; wr_data = 16'd100;
    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
    rd(3'd6, v); check("R11 COUNT write beats reload", v, 100);
    cfg(16'h0200, 0, 7, 16'hFFFF, 9, 0, 7);
    @(negedge clk);
    cnt_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd12;
    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
    rd(3'd2, v); check("R11 CMP1 write beats preload", v, 12);
    rd(3'd6, v); check("R2 reload in same tick", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_updown();
    t_modulo();
    t_flag();
    t_preload();
    t_irq();
    t_prescale();
    t_ext();
    t_idle();
    t_oneshot();
    t_override();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule